// File: doc/BRIEF.md
# FIFO Observer with Dual-Target Interrupts

This block sits next to a multi-FIFO engine and turns the engine's per-access reports into interrupts. Each cycle the engine may report one access: the FIFO number, whether it was a read or a write, and six status flags (underrun, empty-minus-watermark, empty, overflow, full-minus-watermark, full). The engine also reports a bus abort and whether any FIFO access is in progress. Ten observer slots each watch one programmable FIFO number for a selectable subset of events.

All sources land in one shared raw interrupt register that hardware sets and software clears with write-one-to-clear. Two interrupt targets each own a mask. The mask can only be changed through a set register and a clear register, so independent software tasks can change their own bits without a read-modify-write race. Each target has a masked status view and a registered interrupt line.

The block holds no sequencer. Register writes, event capture and interrupt generation all complete in one cycle, with the interrupt lines one register stage behind the raw state.

Top module: `fifo_observer_irq`

## Requirements
- R1: After reset, the raw register, both masks, both masked views, the configuration register, every observer register and both interrupt outputs are zero.
- R2: Raw bit mapping:
  - bit 0 is set by a bus abort.
  - bit 1 is set by any reported read.
  - bit 2 is set by any reported write.
  - bit 3 is set by an active FIFO access.
  - bit 4+i is set by a hit of observer i.
- R3: Writing the raw register (offset 0x00C) with a 1 in a bit clears that bit. A 0 leaves the bit unchanged. No raw bit clears without such a write.
- R4: When a hardware set and a software clear hit the same raw bit in the same cycle, the bit ends up set.
- R5: Each target's mask is changed only through its set and clear registers:
  - Target A uses set 0x014 and clear 0x018. Target B uses set 0x02C and clear 0x030.
  - Writing a 1 to a bit sets or clears that mask bit. Writing a 0 has no effect.
  - Reading either the set or the clear register returns the current mask.
- R6: The masked view of target A (0x010) and of target B (0x028) each read as the raw register ANDed with that target's mask.
- R7: Observer i sits at 0x058+4*i.
  - Bits 9..0 hold the watched FIFO number.
  - The enables are: read in bit 15, underrun in bit 16, empty-minus-watermark in bit 17, empty in bit 18, write in bit 19, overflow in bit 20, full-minus-watermark in bit 21 and full in bit 22.
  - All other bits read zero.
- R8: An observer hit requires three things: a valid report, a FIFO number equal to the watched one, and at least one enabled event present in that report.
  - The event flags input uses this encoding: bit 0 underrun, bit 1 empty-minus-watermark, bit 2 empty, bit 3 overflow, bit 4 full-minus-watermark, bit 5 full.
  - The read event is a report with the write input low. The write event is a report with the write input high.
- R9: Each interrupt output equals the OR of its target's masked status, delayed by one clock.
- R10: The two targets are independent: changing one target's mask leaves the other's mask and interrupt unchanged.
- R11: The configuration register at 0x000 stores bits 31..2. Bits 1..0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address (word aligned) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_valid | input | 1 | An access report is present this cycle |
| evt_fifo | input | 10 | FIFO number of the reported access |
| evt_write | input | 1 | 1 = write access, 0 = read access |
| evt_flags | input | 6 | Status flags of the report (encoding in R8) |
| xfer_abort | input | 1 | Bus abort seen by the engine |
| access_active | input | 1 | A FIFO access is in progress |
| irq_a | output | 1 | Interrupt line of target A |
| irq_b | output | 1 | Interrupt line of target B |

## Verification
The assertions assume the following about the block's inputs:
- The bus address is stable while it is sampled.
- At most one register write occurs per cycle.
- Event flags have meaning only when evt_valid is high. The no-hit checks rely on this.

The stimulus drives every input from one task per clock cycle. Each register access is a single full-word write at an exact mapped address. The only case where an event and a raw clear arrive in the same cycle is the deliberate test of R4.

// File: rtl/fobs_pkg.sv
package fobs_pkg;

    // Register byte offsets
    localparam logic [11:0] OFS_CFG    = 12'h000;
    localparam logic [11:0] OFS_RAW    = 12'h00C;
    localparam logic [11:0] OFS_A_MSKD = 12'h010;
    localparam logic [11:0] OFS_A_SET  = 12'h014;
    localparam logic [11:0] OFS_A_CLR  = 12'h018;
    localparam logic [11:0] OFS_B_MSKD = 12'h028;
    localparam logic [11:0] OFS_B_SET  = 12'h02C;
    localparam logic [11:0] OFS_B_CLR  = 12'h030;
    localparam logic [11:0] OFS_OBS0   = 12'h058;

    // Raw source positions
    localparam int RB_ABORT  = 0;
    localparam int RB_READ   = 1;
    localparam int RB_WRITE  = 2;
    localparam int RB_ACTIVE = 3;
    localparam int RB_OBS0   = 4;

    // Observer enable field lives in bits 22..15 of the observer word
    localparam int OBS_EN_LSB = 15;
    localparam int OBS_EN_MSB = 22;

    typedef struct packed {
        logic full;
        logic fmw;
        logic ovfl;
        logic on_wr;
        logic empty;
        logic emw;
        logic undr;
        logic on_rd;
    } obs_en_t;

    typedef struct packed {
        logic full;
        logic fmw;
        logic ovfl;
        logic empty;
        logic emw;
        logic undr;
    } evt_flags_t;

endpackage

// File: rtl/fobs_slot.sv
module fobs_slot
    import fobs_pkg::*;
#(
    parameter int FNW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [FNW-1:0] cfg_fifo_in,
    input  obs_en_t        cfg_en_in,
    input  logic           evt_valid,
    input  logic [FNW-1:0] evt_fifo,
    input  logic           evt_write,
    input  evt_flags_t     evt_flags,
    output logic [FNW-1:0] watch_fifo,
    output obs_en_t        watch_en,
    output logic           hit
);

    logic [FNW-1:0] fifo_q;
    obs_en_t        en_q;
    logic           any_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
            en_q   <= '0;
        end else if (cfg_we) begin
            fifo_q <= cfg_fifo_in;
            en_q   <= cfg_en_in;
        end
    end

    always_comb begin
        any_evt = (en_q.on_rd &  !evt_write)
                | (en_q.on_wr &   evt_write)
                | (en_q.undr  &   evt_flags.undr)
                | (en_q.emw   &   evt_flags.emw)
                | (en_q.empty &   evt_flags.empty)
                | (en_q.ovfl  &   evt_flags.ovfl)
                | (en_q.fmw   &   evt_flags.fmw)
                | (en_q.full  &   evt_flags.full);
        hit = evt_valid && (evt_fifo == fifo_q) && any_evt;
    end

    assign watch_fifo = fifo_q;
    assign watch_en   = en_q;

    assert_no_hit_mismatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_fifo != watch_fifo) |-> !hit);
    assert_no_hit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> !hit);
    assert_no_hit_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_en == '0) |-> !hit);

endmodule

// File: rtl/fobs_raw.sv
module fobs_raw #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_clr,
    output logic [W-1:0] raw
);

    logic [W-1:0] raw_q;

    // hardware set is applied after the clear, so it wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~sw_clr) | hw_set;
    end

    assign raw = raw_q;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((raw & $past(hw_set)) == $past(hw_set)));
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_clr & ~hw_set) != '0) |=> ((raw & $past(sw_clr & ~hw_set)) == '0));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr == '0) |=> ((raw & $past(raw)) == $past(raw)));

endmodule

// File: rtl/fobs_target.sv
module fobs_target #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked,
    output logic         irq
);

    logic [W-1:0] mask_q;
    logic         irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_we) begin
            mask_q <= mask_q | wdata;
        end else if (clr_we) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    assign masked = raw & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked;
    end

    assign mask = mask_q;
    assign irq  = irq_q;

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & $past(wdata)) == $past(wdata)));
    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));
    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask));
    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & mask) != '0) |=> irq);
    assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & mask) == '0) |=> !irq);

endmodule

// File: rtl/fifo_observer_irq.sv
module fifo_observer_irq
    import fobs_pkg::*;
#(
    parameter int NUM_OBS = 10,
    parameter int FNW     = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        evt_valid,
    input  logic [9:0]  evt_fifo,
    input  logic        evt_write,
    input  logic [5:0]  evt_flags,
    input  logic        xfer_abort,
    input  logic        access_active,
    output logic        irq_a,
    output logic        irq_b
);

    localparam int RAW_W = RB_OBS0 + NUM_OBS;

    logic [31:2]      cfg_q;
    logic [RAW_W-1:0] raw, hw_set, sw_clr;
    logic [RAW_W-1:0] mask_a, mask_b, masked_a, masked_b;
    logic [NUM_OBS-1:0] obs_hit;
    logic [NUM_OBS-1:0] obs_we;
    logic [FNW-1:0]     obs_fifo [NUM_OBS];
    obs_en_t            obs_en   [NUM_OBS];
    evt_flags_t         flags_s;

    assign flags_s = evt_flags_t'(evt_flags);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cfg_q <= '0;
        else if (bus_wr && bus_addr == OFS_CFG) cfg_q <= bus_wdata[31:2];
    end

    for (genvar i = 0; i < NUM_OBS; i++) begin : g_obs
        assign obs_we[i] = bus_wr && (bus_addr == OFS_OBS0 + 12'(4 * i));
        fobs_slot #(.FNW(FNW)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (obs_we[i]),
            .cfg_fifo_in (bus_wdata[FNW-1:0]),
            .cfg_en_in   (obs_en_t'(bus_wdata[OBS_EN_MSB:OBS_EN_LSB])),
            .evt_valid   (evt_valid),
            .evt_fifo    (evt_fifo[FNW-1:0]),
            .evt_write   (evt_write),
            .evt_flags   (flags_s),
            .watch_fifo  (obs_fifo[i]),
            .watch_en    (obs_en[i]),
            .hit         (obs_hit[i])
        );
    end

    always_comb begin
        hw_set = '0;
        hw_set[RB_ABORT]  = xfer_abort;
        hw_set[RB_READ]   = evt_valid && !evt_write;
        hw_set[RB_WRITE]  = evt_valid &&  evt_write;
        hw_set[RB_ACTIVE] = access_active;
        hw_set[RAW_W-1:RB_OBS0] = obs_hit;
        sw_clr = (bus_wr && bus_addr == OFS_RAW) ? bus_wdata[RAW_W-1:0] : '0;
    end

    fobs_raw #(.W(RAW_W)) raw_i (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_clr(sw_clr), .raw(raw)
    );

    fobs_target #(.W(RAW_W)) tgt_a_i (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && bus_addr == OFS_A_SET),
        .clr_we(bus_wr && bus_addr == OFS_A_CLR),
        .wdata(bus_wdata[RAW_W-1:0]), .raw(raw),
        .mask(mask_a), .masked(masked_a), .irq(irq_a)
    );

    fobs_target #(.W(RAW_W)) tgt_b_i (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && bus_addr == OFS_B_SET),
        .clr_we(bus_wr && bus_addr == OFS_B_CLR),
        .wdata(bus_wdata[RAW_W-1:0]), .raw(raw),
        .mask(mask_b), .masked(masked_b), .irq(irq_b)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CFG:              bus_rdata = {cfg_q, 2'b00};
            OFS_RAW:              bus_rdata[RAW_W-1:0] = raw;
            OFS_A_MSKD:           bus_rdata[RAW_W-1:0] = masked_a;
            OFS_A_SET, OFS_A_CLR: bus_rdata[RAW_W-1:0] = mask_a;
            OFS_B_MSKD:           bus_rdata[RAW_W-1:0] = masked_b;
            OFS_B_SET, OFS_B_CLR: bus_rdata[RAW_W-1:0] = mask_b;
            default: begin
                for (int i = 0; i < NUM_OBS; i++) begin
                    if (bus_addr == OFS_OBS0 + 12'(4 * i)) begin
                        bus_rdata[FNW-1:0] = obs_fifo[i];
                        bus_rdata[OBS_EN_MSB:OBS_EN_LSB] = obs_en[i];
                    end
                end
            end
        endcase
    end

    assert_masked_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_A_MSKD) |-> (bus_rdata[RAW_W-1:0] == (raw & mask_a)));
    assert_cfg_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CFG) |-> (bus_rdata[1:0] == 2'b00));

endmodule

// File: tb/fifo_observer_irq_tb_top.sv
module fifo_observer_irq_tb_top;
    import fobs_pkg::*;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic evt_valid = 0, evt_write = 0, xfer_abort = 0, access_active = 0;
    logic [9:0] evt_fifo = '0;
    logic [5:0] evt_flags = '0;
    logic irq_a, irq_b;
    logic probe = 0;

    always #4 clk = ~clk;

    fifo_observer_irq dut_i (.*);

    typedef struct {
        bit          pins;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    int tests_run = 0, tests_failed = 0;
    bit finished = 0;

    logic [13:0] m_raw = '0, m_ma = '0, m_mb = '0;
    logic [9:0]  m_ofifo [10];
    logic [7:0]  m_oen   [10];

    // monitor: compares after the edge the probe was set for
    always @(posedge clk) begin
        if (probe) begin
            sb_item_t it;
            logic [31:0] act;
            #2;
            it  = sb_q.pop_front();
            act = it.pins ? {30'b0, irq_b, irq_a} : bus_rdata;
            tests_run++;
            if (act !== it.exp) begin
                tests_failed++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic drv_idle();
        bus_wr = 0; bus_addr = '0; bus_wdata = '0; probe = 0;
        evt_valid = 0; evt_write = 0; evt_fifo = '0; evt_flags = '0;
        xfer_abort = 0; access_active = 0;
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); drv_idle();
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        case (a)
            OFS_RAW:   m_raw = m_raw & ~d[13:0];
            OFS_A_SET: m_ma  = m_ma | d[13:0];
            OFS_A_CLR: m_ma  = m_ma & ~d[13:0];
            OFS_B_SET: m_mb  = m_mb | d[13:0];
            OFS_B_CLR: m_mb  = m_mb & ~d[13:0];
            default: ;
        endcase
        for (int i = 0; i < 10; i++)
            if (a == OFS_OBS0 + 12'(4 * i)) begin
                m_ofifo[i] = d[9:0]; m_oen[i] = d[22:15];
            end
    endtask

    // one cycle of engine reports, optionally with a raw clear in the same cycle
    task automatic evt(input logic v, input logic [9:0] f, input logic w,
                       input logic [5:0] fl, input logic ab, input logic act,
                       input logic [13:0] clr);
        logic [13:0] s;
        @(negedge clk); drv_idle();
        evt_valid = v; evt_fifo = f; evt_write = w; evt_flags = fl;
        xfer_abort = ab; access_active = act;
        if (clr != '0) begin bus_wr = 1; bus_addr = OFS_RAW; bus_wdata = {18'b0, clr}; end
        s = '0;
        s[0] = ab; s[1] = v && !w; s[2] = v && w; s[3] = act;
        for (int i = 0; i < 10; i++) begin
            logic [7:0] e;
            logic any;
            e = m_oen[i];
            any = (e[0] & !w) | (e[1] & fl[0]) | (e[2] & fl[1]) | (e[3] & fl[2])
                | (e[4] & w) | (e[5] & fl[3]) | (e[6] & fl[4]) | (e[7] & fl[5]);
            s[4+i] = v && (m_ofifo[i] == f) && any;
        end
        m_raw = (m_raw & ~clr) | s;
    endtask

    task automatic chk_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); drv_idle();
        bus_addr = a; probe = 1;
        sb_q.push_back('{pins: 0, exp: e, tag: tag});
    endtask

    task automatic chk_pins(input string tag);
        @(negedge clk); drv_idle();
        probe = 1;
        sb_q.push_back('{pins: 1, exp: {30'b0, |(m_raw & m_mb), |(m_raw & m_ma)}, tag: tag});
    endtask

    task automatic chk_all(input string tag);
        chk_reg(OFS_RAW, {18'b0, m_raw}, {tag, " raw"});
        chk_reg(OFS_A_MSKD, {18'b0, m_raw & m_ma}, "R6 masked A");
        chk_reg(OFS_B_MSKD, {18'b0, m_raw & m_mb}, "R6 masked B");
        chk_pins("R9 irq pins");
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            tests_failed++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) begin m_ofifo[i] = '0; m_oen[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk_reg(OFS_RAW, 0, "R1 raw");
        chk_reg(OFS_A_SET, 0, "R1 mask A");
        chk_reg(OFS_B_CLR, 0, "R1 mask B");
        chk_reg(OFS_CFG, 0, "R1 cfg");
        chk_reg(OFS_OBS0 + 12'h24, 0, "R1 obs9");
        chk_pins("R1 irq pins");
        // R11 config
        reg_wr(OFS_CFG, 32'hFFFF_FFFF);
        chk_reg(OFS_CFG, 32'hFFFF_FFFC, "R11 cfg low bits");
        // R7 observer field layout
        reg_wr(OFS_OBS0 + 12'h08, 32'hFFFF_FFFF);
        chk_reg(OFS_OBS0 + 12'h08, 32'h007F_83FF, "R7 obs2 readback");
        reg_wr(OFS_OBS0 + 12'h08, 32'h0);
        // observer setup
        reg_wr(OFS_OBS0,          (32'd1 << 15) | 32'd5);    // obs0: fifo5 read
        reg_wr(OFS_OBS0 + 12'h0C, (32'd1 << 20) | 32'd7);    // obs3: fifo7 overflow
        reg_wr(OFS_OBS0 + 12'h24, (32'd1 << 22) | 32'd1023); // obs9: fifo1023 full
        chk_reg(OFS_OBS0 + 12'h0C, 32'h0010_0007, "R7 obs3 readback");
        // R2 R8 read hit
        evt(1, 10'd5, 0, 6'b0, 0, 0, 14'h0);
        chk_reg(OFS_RAW, 32'h0000_0012, "R2 R8 read hit fifo5");
        // R3 clear all
        reg_wr(OFS_RAW, 32'h3FFF);
        chk_reg(OFS_RAW, 0, "R3 clear all");
        // R8 enabled event absent
        evt(1, 10'd5, 1, 6'b0, 0, 0, 14'h0);
        chk_reg(OFS_RAW, 32'h0000_0004, "R8 write no hit");
        // R8 overflow hit on fifo7 (bit3 of flags)
        evt(1, 10'd7, 1, 6'b001000, 0, 0, 14'h0);
        chk_reg(OFS_RAW, 32'h0000_0084, "R8 ovfl hit obs3");
        reg_wr(OFS_RAW, 32'h3FFF);
        // R8 mismatch
        evt(1, 10'd6, 0, 6'b001000, 0, 0, 14'h0);
        chk_reg(OFS_RAW, 32'h0000_0002, "R8 fifo mismatch");
        // R8 full on fifo1023 (bit5)
        evt(1, 10'd1023, 1, 6'b100000, 0, 0, 14'h0);
        chk_reg(OFS_RAW, 32'h0000_2006, "R8 full hit obs9");
        // R2 abort and active
        evt(0, 10'd0, 0, 6'b0, 1, 1, 14'h0);
        chk_reg(OFS_RAW, 32'h0000_200F, "R2 abort active");
        // R3 partial and zero write
        reg_wr(OFS_RAW, 32'h0002);
        chk_reg(OFS_RAW, 32'h0000_200D, "R3 partial clear");
        reg_wr(OFS_RAW, 32'h0);
        chk_reg(OFS_RAW, 32'h0000_200D, "R3 zero write no effect");
        // R4 set wins
        evt(1, 10'd9, 0, 6'b0, 0, 0, 14'h0003);
        chk_reg(OFS_RAW, 32'h0000_200E, "R4 set wins bit1");
        // R5 masks
        reg_wr(OFS_A_SET, 32'h0011);
        chk_reg(OFS_A_SET, 32'h0011, "R5 mask A via set");
        chk_reg(OFS_A_CLR, 32'h0011, "R5 mask A via clr");
        chk_all("R6");
        reg_wr(OFS_A_CLR, 32'h0001);
        chk_reg(OFS_A_SET, 32'h0010, "R5 mask A clear bit0");
        chk_pins("R9 irq A low");
        // R10 independence
        reg_wr(OFS_B_SET, 32'h2000);
        chk_reg(OFS_A_SET, 32'h0010, "R10 mask A untouched");
        chk_pins("R10 irq B only");
        reg_wr(OFS_RAW, 32'h2000);
        chk_pins("R9 irq B drops");
        evt(1, 10'd5, 0, 6'b0, 0, 0, 14'h0);
        chk_all("R9 irq A rises");
        reg_wr(OFS_B_CLR, 32'h3FFF);
        chk_reg(OFS_B_SET, 0, "R5 mask B cleared");
        chk_reg(OFS_A_CLR, 32'h0010, "R10 mask A kept");
        chk_pins("R10 irq A kept");
        @(negedge clk); drv_idle();
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            tests_failed++;
            $display("FAIL scoreboard actual=%0d expected=0 left", sb_q.size());
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule